// File: doc/BRIEF.md
# Linear flash read buffer

This block serves memory-mapped reads for code that executes directly out of serial flash. It holds one line of 1024 bytes together with an address tag. A bus read that falls inside the line is answered from the line as a 32-bit little-endian word. A bus read that falls outside it stalls the bus. The block then aligns the address to a 1024-byte boundary and converts it to a flash address by dividing by the number of active buses. It picks the lower or upper flash device, refills the whole line one byte at a time through a request/acknowledge interface to an external flash engine, and then answers the original read from the new line.

The block supports two modes. In single-bus mode every line byte comes from bus 0. In parallel mode two flash devices sit side by side, and the fill alternates between bus 0 and bus 1 so that line bytes follow bus address order. A strobe marks writes to the linear-mode configuration, and any such write makes the stored line unusable. The flash command engine that performs the byte reads is outside this block.

Top module: `flash_line_buffer`

## Requirements
- R1: After reset `rd_ready` is 1, `rd_valid` is 0, `fill_req` is 0 and `upper_sel` is 0. The line is invalid, so the first read causes a fill.
- R2: A read whose address `a` satisfies tag <= a <= tag + 1020 is a hit. It issues no fill request and returns line bytes `a-tag` to `a-tag+3` as `rd_data[7:0]` to `rd_data[31:24]`. `rd_valid` is high in the cycle right after the acceptance edge.
- R3: Any other read is a miss. It issues exactly 1024 byte requests, which fill the line for the address rounded down to a multiple of 1024.
- R4: The flash address is the aligned address divided by 1 in single-bus mode or by 2 when `par_mode` is 1. In single-bus mode, line byte i is requested on bus 0 (`fill_bus`=0) at device offset flash_address[23:0] + i.
- R5: In parallel mode, line byte i is requested on bus i mod 2 at device offset flash_address[23:0] + i/2. Bus 0 therefore supplies the even bytes.
- R6: On a miss, `upper_sel` takes the value 1 if any flash-address bit at position 24 or above is set, and 0 otherwise. The value is set before the first fill request, and `upper_sel` changes only on the acceptance edge of a miss.
- R7: At the end of a fill the tag becomes the flash address times the bus count. The pending read is then answered from the new line.
- R8: A `cfg_wr` pulse makes the line invalid. The next read misses even at an address that hit before. A read accepted in the same cycle as `cfg_wr` is still looked up against the old tag.
- R9: A `cfg_wr` from the acceptance edge of a miss up to and including the cycle of the last fill acknowledge leaves the line invalid after the fill. The pending read still returns the freshly filled data.
- R10: `rd_ready` is high only while the block is idle. It stays low from acceptance until `rd_valid`, and `rd_valid` lasts exactly one cycle.
- R11: A read at line offset 1021 to 1023 always misses. After the fill it is served with line indices that wrap modulo 1024.
- R12: `fill_req` together with `fill_addr` and `fill_bus` holds steady until `fill_ack` is sampled high, and each acknowledge writes `fill_data` into the current line byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Bus read request |
| rd_addr | input | ADDR_W | Bus byte address of the read |
| rd_ready | output | 1 | Request accepted at an edge where this and rd_req are high |
| rd_data | output | 32 | Little-endian read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| par_mode | input | 1 | 1 selects two buses side by side |
| cfg_wr | input | 1 | Pulse for a write to the linear-mode configuration |
| upper_sel | output | 1 | Upper flash device selected |
| fill_req | output | 1 | Byte read request to the flash engine |
| fill_addr | output | DEV_AW | Byte offset within the flash device |
| fill_bus | output | 1 | Bus that the requested byte comes from |
| fill_ack | input | 1 | Byte returned by the flash engine |
| fill_data | input | 8 | Returned byte |

## Verification
A configuration write can fall in the same cycle as two other events: the last acknowledge of a fill, where it competes with the tag load, and the acceptance of a hit, where it competes with the lookup. The bench forces the first case by having its flash responder raise `cfg_wr` together with acknowledge number 1024. It forces the second case by driving `cfg_wr` alongside `rd_req` on a line known to be valid. In both cases the read in flight must return the correct word, and a repeat read of the same address must trigger a full 1024-byte fill.

// File: rtl/xlb_pkg.sv
// Shared types of the linear flash read buffer.
package xlb_pkg;
    // Control state of the bus read path.
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_FILL  = 2'd1,
        XS_SERVE = 2'd2,
        XS_RESP  = 2'd3
    } xlb_state_e;
endpackage

// File: rtl/xlb_tag.sv
// Line tag holder and hit comparator.
// The tag carries one extra bit, so the all-ones value lies above every bus
// address and cannot hit. A stale flag records configuration writes that
// arrive while a fill is running, so the tag is not loaded when the fill ends.
// Assumes arm and load never occur in the same cycle.
module xlb_tag #(
    parameter int ADDR_W     = 26,
    parameter int LINE_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              inval,
    input  logic              arm,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_tag,
    output logic              hit
);
    localparam int TAG_W = ADDR_W + 1;
    localparam int CMP_W = ADDR_W + 2;
    localparam int SPAN  = LINE_BYTES - 4;

    logic [TAG_W-1:0] tag_q;
    logic             stale_q;
    logic [CMP_W-1:0] lo_bound;
    logic [CMP_W-1:0] hi_bound;
    logic [CMP_W-1:0] probe_ext;

    // Keep the tag and the stale flag of the fill in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '1;
            stale_q <= 1'b0;
        end else begin
            if (arm) begin
                stale_q <= inval;
            end else if (inval) begin
                stale_q <= 1'b1;
            end
            if (inval || arm) begin
                tag_q <= '1;
            end else if (load && !stale_q) begin
                tag_q <= {1'b0, load_tag};
            end
        end
    end

    // Range check of the probe address against the current tag.
    always_comb begin
        probe_ext = {2'b00, probe_addr};
        lo_bound  = {1'b0, tag_q};
        hi_bound  = {1'b0, tag_q} + CMP_W'(SPAN);
        hit       = (probe_ext >= lo_bound) && (probe_ext <= hi_bound);
    end
endmodule

// File: rtl/xlb_line_store.sv
// Byte storage for the line: one write port for fills and a read port
// that returns WORD_BYTES consecutive bytes, least significant byte first.
// Assumes LINE_BYTES is a power of two, so read indices wrap modulo the line.
module xlb_line_store #(
    parameter int LINE_BYTES = 1024,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(LINE_BYTES)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_byte,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [8*WORD_BYTES-1:0] rd_word
);
    logic [7:0] mem [LINE_BYTES];

    // Write one filled byte.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_byte;
        end
    end

    // One read lane per byte of the word; the index wraps at the line end.
    for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        assign lane_idx = rd_idx + IDX_W'(lane);
        assign rd_word[8*lane +: 8] = mem[lane_idx];
    end
endmodule

// File: rtl/xlb_fill_seq.sv
// Fill sequencer: issues one byte request per line byte, in line order,
// and reports each acknowledged byte as a line write.
// In parallel mode even bytes come from bus 0 and odd bytes from bus 1;
// both buses read the same device offset for each pair.
module xlb_fill_seq #(
    parameter int DEV_AW     = 24,
    parameter int LINE_BYTES = 1024,
    localparam int IDX_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              par_in,
    input  logic [DEV_AW-1:0] base_off,
    input  logic              fill_ack,
    output logic              fill_req,
    output logic [DEV_AW-1:0] fill_addr,
    output logic              fill_bus,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_BYTES - 1);

    logic              busy_q;
    logic              par_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [DEV_AW-1:0] base_q;
    logic [IDX_W-1:0]  step;

    // Derive the request fields and the line write from the byte counter.
    always_comb begin
        step      = par_q ? (cnt_q >> 1) : cnt_q;
        fill_req  = busy_q;
        fill_bus  = par_q & cnt_q[0];
        fill_addr = base_q + DEV_AW'(step);
        wr_en     = busy_q & fill_ack;
        wr_idx    = cnt_q;
        done      = wr_en && (cnt_q == LAST_IDX);
    end

    // Advance the byte counter on each acknowledge; stop after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            par_q  <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            par_q  <= par_in;
            cnt_q  <= '0;
            base_q <= base_off;
        end else if (wr_en) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_line_buffer.sv
// Linear flash read buffer top level.
// Accepts one bus read at a time. A hit answers one cycle after acceptance.
// A miss aligns the address, converts it to a flash address, selects the
// device, refills the line through the byte interface and then answers.
// Assumes ADDR_W > DEV_AW and a power-of-two LINE_BYTES of at least 8.
module flash_line_buffer #(
    parameter int ADDR_W     = 26,
    parameter int DEV_AW     = 24,
    parameter int LINE_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic              par_mode,
    input  logic              cfg_wr,
    output logic              upper_sel,
    output logic              fill_req,
    output logic [DEV_AW-1:0] fill_addr,
    output logic              fill_bus,
    input  logic              fill_ack,
    input  logic [7:0]        fill_data
);
    import xlb_pkg::*;

    localparam int IDX_W = $clog2(LINE_BYTES);

    xlb_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       data_q;
    logic              upper_q;
    logic [ADDR_W-1:0] load_tag_q;

    logic              accept;
    logic              hit;
    logic              miss_start;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] flash_a;
    logic [ADDR_W-1:0] scaled_tag;
    logic              new_upper;
    logic [IDX_W-1:0]  rd_idx;
    logic [31:0]       rd_word;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              fill_done;

    // Decode of the incoming request: alignment, flash address, device, tag.
    always_comb begin
        accept     = (state_q == XS_IDLE) && rd_req;
        miss_start = accept && !hit;
        aligned    = {rd_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        flash_a    = par_mode ? (aligned >> 1) : aligned;
        new_upper  = |flash_a[ADDR_W-1:DEV_AW];
        scaled_tag = par_mode ? {flash_a[ADDR_W-2:0], 1'b0} : flash_a;
        rd_idx     = (state_q == XS_IDLE) ? rd_addr[IDX_W-1:0] : idx_q;
    end

    xlb_tag #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_addr(rd_addr),
        .inval     (cfg_wr),
        .arm       (miss_start),
        .load      (fill_done),
        .load_tag  (load_tag_q),
        .hit       (hit)
    );

    xlb_line_store #(
        .LINE_BYTES(LINE_BYTES),
        .WORD_BYTES(4)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_byte(fill_data),
        .rd_idx (rd_idx),
        .rd_word(rd_word)
    );

    xlb_fill_seq #(
        .DEV_AW    (DEV_AW),
        .LINE_BYTES(LINE_BYTES)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (miss_start),
        .par_in   (par_mode),
        .base_off (flash_a[DEV_AW-1:0]),
        .fill_ack (fill_ack),
        .fill_req (fill_req),
        .fill_addr(fill_addr),
        .fill_bus (fill_bus),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .done     (fill_done)
    );

    // Read path sequencing: lookup, fill, serve from the new line, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= XS_IDLE;
            idx_q      <= '0;
            data_q     <= '0;
            upper_q    <= 1'b0;
            load_tag_q <= '0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (accept) begin
                        idx_q <= rd_addr[IDX_W-1:0];
                        if (hit) begin
                            data_q  <= rd_word;
                            state_q <= XS_RESP;
                        end else begin
                            upper_q    <= new_upper;
                            load_tag_q <= scaled_tag;
                            state_q    <= XS_FILL;
                        end
                    end
                end
                XS_FILL: begin
                    if (fill_done) begin
                        state_q <= XS_SERVE;
                    end
                end
                XS_SERVE: begin
                    data_q  <= rd_word;
                    state_q <= XS_RESP;
                end
                default: begin
                    state_q <= XS_IDLE;
                end
            endcase
        end
    end

    assign rd_ready  = (state_q == XS_IDLE);
    assign rd_valid  = (state_q == XS_RESP);
    assign rd_data   = data_q;
    assign upper_sel = upper_q;
endmodule

// File: rtl/flash_line_buffer_chk.sv
// Protocol checker for the linear flash read buffer, bound to the top level.
module flash_line_buffer_chk #(
    parameter int DEV_AW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic              upper_sel,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [DEV_AW-1:0] fill_addr,
    input logic              fill_bus
);
    // R10: idle, responding and filling never overlap.
    p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ready, rd_valid, fill_req}));

    // R10: the response lasts exactly one cycle.
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R12: an unacknowledged byte request holds its fields.
    p_fill_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr) && $stable(fill_bus)));

    // R6: the device select moves only on an accepted request.
    p_upper_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(upper_sel) |-> $past(rd_req && rd_ready));

    // R3: a fill never begins while a response is shown.
    p_fill_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(rd_req && rd_ready));
endmodule

bind flash_line_buffer flash_line_buffer_chk #(.DEV_AW(DEV_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .upper_sel(upper_sel),
    .fill_req (fill_req),
    .fill_ack (fill_ack),
    .fill_addr(fill_addr),
    .fill_bus (fill_bus)
);

// File: tb/tb_flash_line_buffer.sv
module tb_flash_line_buffer;
    localparam int ADDR_W = 26;
    localparam int DEV_AW = 24;
    localparam int LINE   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic              par_mode = 1'b0;
    logic              cfg_wr;
    logic              cfg_main = 1'b0;
    logic              cfg_last = 1'b0;
    logic              upper_sel;
    logic              fill_req;
    logic [DEV_AW-1:0] fill_addr;
    logic              fill_bus;
    logic              fill_ack = 1'b0;
    logic [7:0]        fill_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int ack_cnt = 0;
    bit arm_last = 1'b0;
    bit done_flag = 1'b0;

    // Reference line state
    bit                ref_valid = 1'b0;
    logic [ADDR_W-1:0] ref_base = '0;
    bit                ref_par = 1'b0;
    bit                ref_upper = 1'b0;

    assign cfg_wr = cfg_main | cfg_last;

    always #5 clk = ~clk;

    flash_line_buffer #(.ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .LINE_BYTES(LINE)) dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .par_mode(par_mode), .cfg_wr(cfg_wr), .upper_sel(upper_sel),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_bus(fill_bus),
        .fill_ack(fill_ack), .fill_data(fill_data)
    );

    function automatic logic [7:0] fbyte(input bit dev, input bit bus, input logic [23:0] off);
        logic [7:0] v;
        v = off[7:0] ^ 8'(off[15:8] * 3) ^ 8'(off[23:16] * 5);
        if (dev) v = v ^ 8'h5A;
        if (bus) v = v ^ 8'hC3;
        return v;
    endfunction

    function automatic bit dev_of(input logic [ADDR_W-1:0] base, input bit p);
        logic [ADDR_W-1:0] fa;
        fa = p ? (base >> 1) : base;
        return |fa[ADDR_W-1:24];
    endfunction

    function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base, input bit p);
        logic [ADDR_W-1:0] fa;
        logic [9:0]  idx;
        logic [23:0] o;
        logic [31:0] w;
        bit b;
        bit dev;
        fa  = p ? (base >> 1) : base;
        dev = dev_of(base, p);
        for (int j = 0; j < 4; j++) begin
            idx = 10'(a - base + ADDR_W'(j));
            b   = p ? idx[0] : 1'b0;
            o   = fa[23:0] + (p ? 24'(idx >> 1) : 24'(idx));
            w[8*j +: 8] = fbyte(dev, b, o);
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flash engine model: random latency, data depends on device, bus, offset.
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            fill_ack = 1'b0;
            cfg_last = 1'b0;
            if (fill_req) begin
                if (lat == 0) begin
                    fill_ack  = 1'b1;
                    fill_data = fbyte(upper_sel, fill_bus, fill_addr);
                    ack_cnt++;
                    if (arm_last && ack_cnt == LINE) cfg_last = 1'b1;
                    lat = int'($urandom % 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    // One read with reference prediction and checks.
    task automatic check_read(input logic [ADDR_W-1:0] a, input bit p, input bit cfg_same,
                              input string tag);
        bit exp_hit;
        logic [ADDR_W-1:0] base;
        bit bp;
        logic [31:0] ew;
        int cyc;
        bit ready_leak;
        exp_hit = ref_valid && ({1'b0, a} >= {1'b0, ref_base}) &&
                  ({1'b0, a} <= {1'b0, ref_base} + 27'd1020);
        if (exp_hit) begin
            base = ref_base; bp = ref_par;
        end else begin
            base = {a[ADDR_W-1:10], 10'd0}; bp = p;
        end
        ew = exp_word(a, base, bp);
        @(negedge clk);
        chk(rd_ready, {tag, " R10 ready idle"}, 32'(rd_ready), 32'd1);
        ack_cnt = 0;
        rd_addr = a; par_mode = p; rd_req = 1'b1; cfg_main = cfg_same;
        @(negedge clk);
        rd_req = 1'b0; cfg_main = 1'b0;
        cyc = 1;
        ready_leak = 1'b0;
        while (!rd_valid && cyc < 20000) begin
            if (rd_ready) ready_leak = 1'b1;
            @(negedge clk);
            cyc++;
        end
        chk(!ready_leak, {tag, " R10 ready low until valid"}, 32'(ready_leak), 32'd0);
        chk(rd_data == ew, {tag, exp_hit ? " R2 hit data" : " R7 fill data"}, rd_data, ew);
        chk(ack_cnt == (exp_hit ? 0 : LINE), {tag, exp_hit ? " R2 no fill" : " R3 fill length"},
            32'(ack_cnt), exp_hit ? 32'd0 : 32'd1024);
        if (exp_hit) chk(cyc == 1, {tag, " R2 hit latency"}, 32'(cyc), 32'd1);
        if (!exp_hit) ref_upper = dev_of(base, bp);
        chk(upper_sel == ref_upper, {tag, " R6 upper select"}, 32'(upper_sel), 32'(ref_upper));
        if (!exp_hit) begin
            ref_valid = 1'b1; ref_base = base; ref_par = bp;
        end
        if (cfg_same || (!exp_hit && arm_last)) ref_valid = 1'b0;
        @(negedge clk);
        chk(!rd_valid, {tag, " R10 valid one cycle"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic pulse_cfg();
        @(negedge clk);
        cfg_main = 1'b1;
        @(negedge clk);
        cfg_main = 1'b0;
        ref_valid = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rd_ready == 1'b1, "R1 ready", 32'(rd_ready), 32'd1);
        chk(rd_valid == 1'b0, "R1 valid", 32'(rd_valid), 32'd0);
        chk(fill_req == 1'b0, "R1 fill_req", 32'(fill_req), 32'd0);
        chk(upper_sel == 1'b0, "R1 upper", 32'(upper_sel), 32'd0);
        // R1/R3/R4: first read misses, single bus
        check_read(26'h0000104, 1'b0, 1'b0, "R1 R4 first");
        // R2: hits, including the last legal offset and an unaligned one
        check_read(26'h0000000, 1'b0, 1'b0, "R2 low edge");
        check_read(26'h00003FC, 1'b0, 1'b0, "R2 high edge");
        check_read(26'h0000123, 1'b0, 1'b0, "R2 unaligned");
        // R11: offset past 1020 misses and wraps
        check_read(26'h00003FE, 1'b0, 1'b0, "R11 wrap");
        // R8: config write invalidates
        pulse_cfg();
        check_read(26'h0000200, 1'b0, 1'b0, "R8 after cfg");
        // R5: parallel mode fill
        pulse_cfg();
        check_read(26'h0000C10, 1'b1, 1'b0, "R5 parallel");
        check_read(26'h0000FFC, 1'b1, 1'b0, "R5 parallel hit");
        // R6: device selection
        check_read(26'h1000400, 1'b0, 1'b0, "R6 single upper");
        check_read(26'h1000400, 1'b1, 1'b0, "R6 parallel lower");
        check_read(26'h2000800, 1'b1, 1'b0, "R6 parallel upper");
        check_read(26'h0000000, 1'b0, 1'b0, "R6 back lower");
        // R8: cfg in the same cycle as a hit acceptance
        check_read(26'h0000010, 1'b0, 1'b1, "R8 cfg with hit");
        check_read(26'h0000010, 1'b0, 1'b0, "R8 miss after cfg");
        // R9: cfg in the cycle of the last fill acknowledge
        pulse_cfg();
        arm_last = 1'b1;
        check_read(26'h0123400, 1'b1, 1'b0, "R9 cfg on last ack");
        arm_last = 1'b0;
        check_read(26'h0123404, 1'b1, 1'b0, "R9 refill after");
        // R9: cfg in the cycle a miss is accepted
        check_read(26'h0456800, 1'b0, 1'b1, "R9 cfg with miss");
        check_read(26'h0456808, 1'b0, 1'b0, "R9 refill after miss cfg");
        // Random mix, mostly hits
        for (int k = 0; k < 160; k++) begin
            logic [ADDR_W-1:0] a;
            bit p;
            bit c;
            int r;
            r = int'($urandom % 100);
            p = ref_par;
            c = 1'b0;
            if (ref_valid && r < 85) begin
                a = ref_base + ADDR_W'($urandom % 1021);
            end else begin
                a = ADDR_W'($urandom);
                p = 1'($urandom);
            end
            if (r >= 95) c = 1'b1;
            check_read(a, p, c, "R2 R3 R12 random");
        end
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule